// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of the instruction now in the execute stage of a five-stage in-order pipeline, where the operand value should come from. Three sources are possible. The first is the value read from the register file during decode. The second is the ALU result held in the execute/memory latch. The third is the value that the memory/writeback latch is about to write back. The decision uses the two source register indices of the executing instruction and the destination index and write-enable of each of the two older instructions.

The selection logic is purely combinational. A thin wrapper applies each select to a three-input operand multiplexer, so the chosen values can be seen at the ports. The write-enable and destination of a stalled bubble are both zero. Because of this, a load that was separated from its consumer by a one-cycle stall reaches the ALU through the writeback path with no extra handling.

Top module: `opfwd_unit`

## Requirements
- R1: When no older stage qualifies for a source register, that operand's select is 2'b00 and the operand equals the register-file value.
- R2: When the execute/memory stage has its write-enable set and a nonzero destination equal to the source register, the select is 2'b10 and the operand equals the execute/memory ALU result.
- R3: When only the memory/writeback stage has its write-enable set and a nonzero destination equal to the source register, the select is 2'b01 and the operand equals the writeback value.
- R4: When both older stages qualify for the same source register, the execute/memory stage wins (select 2'b10).
- R5: A destination index of 0 never causes forwarding, even with the write-enable set; the select value 2'b11 never appears.
- R6: A stage whose write-enable is 0 never supplies a forwarded value, even when its destination index matches.
- R7: Operand A depends only on the first source index (rs) and operand B only on the second (rt), so the two selects can differ in the same cycle.
- R8: A loaded value sitting in the memory/writeback stage behind a bubble (write-enable 0, destination 0) in the execute/memory stage reaches the dependent operand through select 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register index of the executing instruction |
| ex_rt | input | 5 | Second source register index of the executing instruction |
| mem_regwr | input | 1 | Write-enable of the instruction in the execute/memory latch |
| mem_rd | input | 5 | Destination index of the instruction in the execute/memory latch |
| wb_regwr | input | 1 | Write-enable of the instruction in the memory/writeback latch |
| wb_rd | input | 5 | Destination index of the instruction in the memory/writeback latch |
| rf_a | input | 32 | Register-file value for operand A |
| rf_b | input | 32 | Register-file value for operand B |
| mem_alu_res | input | 32 | ALU result held in the execute/memory latch |
| wb_value | input | 32 | Value being written back from the memory/writeback latch |
| sel_a | output | 2 | Source select for operand A (00 file, 10 execute/memory, 01 writeback) |
| sel_b | output | 2 | Source select for operand B (same encoding) |
| alu_a | output | 32 | Selected operand A |
| alu_b | output | 32 | Selected operand B |

## Verification
The selector is exercised with index patterns that have no match, a single match in either older stage, and a match in both stages at once. Together these show the three select codes and the priority between stages. Further patterns put register 0 as the destination, or match indices with the write-enable cleared, so that a guard missing on either field shows up. Other vectors give rs and rt different matches, which exposes any crossing of the operand paths. A bubble-then-load pattern with distinct data values confirms that the writeback path carries the loaded word to both operands.

// File: rtl/opfwd_pkg.sv
`timescale 1ns/1ps
package opfwd_pkg;
    typedef enum logic [1:0] {
        OPSRC_RF  = 2'b00,
        OPSRC_WB  = 2'b01,
        OPSRC_MEM = 2'b10
    } opsrc_e;
endpackage

// File: rtl/opfwd_src_pick.sv
`timescale 1ns/1ps
// Chooses the source of one operand from the two older stages' destinations.
module opfwd_src_pick
    import opfwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             mem_wr,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             wb_wr,
    input  logic [IDX_W-1:0] wb_dst,
    output opsrc_e           sel
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    typedef struct packed {
        logic mem_hit;
        logic wb_hit;
    } hit_t;

    hit_t hit_d;

    always_comb begin
        hit_d.mem_hit = mem_wr && (mem_dst != ZERO_IDX) && (mem_dst == src_idx);
        hit_d.wb_hit  = wb_wr  && (wb_dst  != ZERO_IDX) && (wb_dst  == src_idx);
        // the younger result takes precedence
        if (hit_d.mem_hit)
            sel = OPSRC_MEM;
        else if (hit_d.wb_hit)
            sel = OPSRC_WB;
        else
            sel = OPSRC_RF;
    end
endmodule

// File: rtl/opfwd_mux3.sv
`timescale 1ns/1ps
// Three-way operand multiplexer driven by the source select.
module opfwd_mux3
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opsrc_e            sel,
    input  logic [DATA_W-1:0] from_rf,
    input  logic [DATA_W-1:0] from_mem,
    input  logic [DATA_W-1:0] from_wb,
    output logic [DATA_W-1:0] operand
);
    always_comb begin
        unique case (sel)
            OPSRC_MEM: operand = from_mem;
            OPSRC_WB:  operand = from_wb;
            default:   operand = from_rf;
        endcase
    end
endmodule

// File: rtl/opfwd_unit.sv
`timescale 1ns/1ps
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  ex_rs,
    input  logic [IDX_W-1:0]  ex_rt,
    input  logic              mem_regwr,
    input  logic [IDX_W-1:0]  mem_rd,
    input  logic              wb_regwr,
    input  logic [IDX_W-1:0]  wb_rd,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] mem_alu_res,
    input  logic [DATA_W-1:0] wb_value,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b
);
    localparam int NUM_OPS = 2;

    logic [IDX_W-1:0]  src_vec [NUM_OPS];
    logic [DATA_W-1:0] rf_vec  [NUM_OPS];
    logic [DATA_W-1:0] op_vec  [NUM_OPS];
    opsrc_e            sel_vec [NUM_OPS];

    assign src_vec[0] = ex_rs;
    assign src_vec[1] = ex_rt;
    assign rf_vec[0]  = rf_a;
    assign rf_vec[1]  = rf_b;

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_operand
        opfwd_src_pick #(.IDX_W(IDX_W)) u_pick (
            .src_idx (src_vec[op]),
            .mem_wr  (mem_regwr),
            .mem_dst (mem_rd),
            .wb_wr   (wb_regwr),
            .wb_dst  (wb_rd),
            .sel     (sel_vec[op])
        );

        opfwd_mux3 #(.DATA_W(DATA_W)) u_mux (
            .sel      (sel_vec[op]),
            .from_rf  (rf_vec[op]),
            .from_mem (mem_alu_res),
            .from_wb  (wb_value),
            .operand  (op_vec[op])
        );
    end

    assign sel_a = sel_vec[0];
    assign sel_b = sel_vec[1];
    assign alu_a = op_vec[0];
    assign alu_b = op_vec[1];
endmodule

// File: rtl/opfwd_checker.sv
`timescale 1ns/1ps
module opfwd_checker #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [IDX_W-1:0]  ex_rs,
    input logic [IDX_W-1:0]  ex_rt,
    input logic              mem_regwr,
    input logic [IDX_W-1:0]  mem_rd,
    input logic              wb_regwr,
    input logic [IDX_W-1:0]  wb_rd,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic [DATA_W-1:0] mem_alu_res,
    input logic [DATA_W-1:0] wb_value,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] alu_a,
    input logic [DATA_W-1:0] alu_b
);
    always_comb begin
        AST_A_FILE_PATH: assert (sel_a != 2'b00 || alu_a == rf_a);                               // R1
        AST_B_FILE_PATH: assert (sel_b != 2'b00 || alu_b == rf_b);                               // R1
        AST_A_MEM_PATH: assert (sel_a != 2'b10 || (alu_a == mem_alu_res && mem_rd == ex_rs));    // R2
        AST_B_MEM_PATH: assert (sel_b != 2'b10 || (alu_b == mem_alu_res && mem_rd == ex_rt));    // R2
        AST_A_WB_PATH: assert (sel_a != 2'b01 || (alu_a == wb_value && wb_rd == ex_rs));         // R3
        AST_B_WB_PATH: assert (sel_b != 2'b01 || (alu_b == wb_value && wb_rd == ex_rt));         // R3
        AST_A_YOUNGER_WINS: assert (!(mem_regwr && mem_rd != '0 && mem_rd == ex_rs) || sel_a == 2'b10); // R4
        AST_B_YOUNGER_WINS: assert (!(mem_regwr && mem_rd != '0 && mem_rd == ex_rt) || sel_b == 2'b10); // R4
        AST_NO_CODE_THREE: assert (sel_a != 2'b11 && sel_b != 2'b11);                            // R5
        AST_ZERO_NEVER_FWD: assert ((sel_a == 2'b00 || ex_rs != '0) && (sel_b == 2'b00 || ex_rt != '0)); // R5
        AST_MEM_NEEDS_WR: assert ((sel_a != 2'b10 && sel_b != 2'b10) || mem_regwr);              // R6
        AST_WB_NEEDS_WR: assert ((sel_a != 2'b01 && sel_b != 2'b01) || wb_regwr);                // R6
    end
endmodule

bind opfwd_unit opfwd_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .ex_rs       (ex_rs),
    .ex_rt       (ex_rt),
    .mem_regwr   (mem_regwr),
    .mem_rd      (mem_rd),
    .wb_regwr    (wb_regwr),
    .wb_rd       (wb_rd),
    .rf_a        (rf_a),
    .rf_b        (rf_b),
    .mem_alu_res (mem_alu_res),
    .wb_value    (wb_value),
    .sel_a       (sel_a),
    .sel_b       (sel_b),
    .alu_a       (alu_a),
    .alu_b       (alu_b)
);

// File: tb/sim_opfwd_unit.sv
`timescale 1ns/1ps
module sim_opfwd_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [4:0]  ex_rs = '0, ex_rt = '0, mem_rd = '0, wb_rd = '0;
    logic        mem_regwr = 1'b0, wb_regwr = 1'b0;
    logic [31:0] rf_a = '0, rf_b = '0, mem_alu_res = '0, wb_value = '0;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] alu_a, alu_b;

    opfwd_unit u0 (
        .ex_rs(ex_rs), .ex_rt(ex_rt),
        .mem_regwr(mem_regwr), .mem_rd(mem_rd),
        .wb_regwr(wb_regwr), .wb_rd(wb_rd),
        .rf_a(rf_a), .rf_b(rf_b),
        .mem_alu_res(mem_alu_res), .wb_value(wb_value),
        .sel_a(sel_a), .sel_b(sel_b), .alu_a(alu_a), .alu_b(alu_b)
    );

    typedef struct {
        bit [31:0]   tag;
        logic [1:0]  sa, sb;
        logic [31:0] va, vb;
    } exp_t;

    exp_t exp_q[$];
    int   n_total = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf,
                                         input logic [31:0] m, input logic [31:0] w);
        if (s == 2'b10) return m;
        if (s == 2'b01) return w;
        return rf;
    endfunction

    // driver: applies one vector after a rising edge, queues what should appear
    task automatic drive(input bit [31:0] tag,
                         input logic [4:0] rs, input logic [4:0] rt,
                         input logic mw, input logic [4:0] md,
                         input logic ww, input logic [4:0] wd,
                         input logic [31:0] da, input logic [31:0] db,
                         input logic [31:0] dm, input logic [31:0] dw,
                         input logic [1:0] esa, input logic [1:0] esb);
        exp_t e;
        @(posedge clk);
        #1;
        ex_rs = rs; ex_rt = rt; mem_regwr = mw; mem_rd = md; wb_regwr = ww; wb_rd = wd;
        rf_a = da; rf_b = db; mem_alu_res = dm; wb_value = dw;
        e.tag = tag; e.sa = esa; e.sb = esb;
        e.va = pick(esa, da, dm, dw);
        e.vb = pick(esb, db, dm, dw);
        exp_q.push_back(e);
    endtask

    // monitor: compares at the falling edge after each vector settles
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_total++;
                if (sel_a !== e.sa || sel_b !== e.sb || alu_a !== e.va || alu_b !== e.vb) begin
                    n_fail++;
                    $display("FAIL %0s: sel_a=%b sel_b=%b alu_a=%h alu_b=%h expected sel_a=%b sel_b=%b alu_a=%h alu_b=%h",
                             e.tag, sel_a, sel_b, alu_a, alu_b, e.sa, e.sb, e.va, e.vb);
                end
            end
        end
    end

    localparam logic [31:0] DA = 32'h1111_1111, DB = 32'h2222_2222;
    localparam logic [31:0] DM = 32'h3333_3333, DW = 32'h4444_4444;

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // reset-like idle state: all indices zero
        drive("R1", 5'd0,  5'd0,  1'b0, 5'd0,  1'b0, 5'd0,  DA, DB, DM, DW, 2'b00, 2'b00);
        drive("R1", 5'd3,  5'd4,  1'b1, 5'd5,  1'b1, 5'd6,  DA, DB, DM, DW, 2'b00, 2'b00);
        drive("R2", 5'd2,  5'd7,  1'b1, 5'd2,  1'b0, 5'd0,  DA, DB, DM, DW, 2'b10, 2'b00);
        drive("R2", 5'd1,  5'd9,  1'b1, 5'd9,  1'b0, 5'd1,  DA, DB, DM, DW, 2'b00, 2'b10);
        drive("R3", 5'd12, 5'd1,  1'b1, 5'd13, 1'b1, 5'd12, DA, DB, DM, DW, 2'b01, 2'b00);
        drive("R3", 5'd30, 5'd31, 1'b0, 5'd0,  1'b1, 5'd31, DA, DB, DM, DW, 2'b00, 2'b01);
        drive("R4", 5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 5'd5,  DA, DB, DM, DW, 2'b10, 2'b10);
        drive("R4", 5'd5,  5'd6,  1'b1, 5'd6,  1'b1, 5'd6,  DA, DB, DM, DW, 2'b00, 2'b10);
        drive("R5", 5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  DA, DB, DM, DW, 2'b00, 2'b00);
        drive("R5", 5'd0,  5'd8,  1'b1, 5'd0,  1'b1, 5'd8,  DA, DB, DM, DW, 2'b00, 2'b01);
        drive("R6", 5'd7,  5'd7,  1'b0, 5'd7,  1'b0, 5'd7,  DA, DB, DM, DW, 2'b00, 2'b00);
        drive("R6", 5'd7,  5'd3,  1'b0, 5'd7,  1'b1, 5'd7,  DA, DB, DM, DW, 2'b01, 2'b00);
        drive("R7", 5'd10, 5'd11, 1'b1, 5'd11, 1'b1, 5'd10, DA, DB, DM, DW, 2'b01, 2'b10);
        drive("R7", 5'd11, 5'd10, 1'b1, 5'd11, 1'b1, 5'd10, DA, DB, DM, DW, 2'b10, 2'b01);
        // load consumer after a one-cycle bubble in the execute/memory latch
        drive("R8", 5'd2,  5'd2,  1'b0, 5'd0,  1'b1, 5'd2,  32'hA5A5_0001, 32'h5A5A_0002,
              32'h0000_0BAD, 32'hCAFE_F00D, 2'b01, 2'b01);
        drive("R8", 5'd2,  5'd4,  1'b0, 5'd0,  1'b1, 5'd2,  32'h0, 32'h0000_0044,
              32'hDEAD_0000, 32'h1234_5678, 2'b01, 2'b00);
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule